// File: doc/BRIEF.md
# Processor Reset Qualification Sequencer

This block sits between an already synchronized, active-high reset line and a small processor core. It turns that line into the controls the core needs. An abort strobe fires on the first cycle the line is seen high. Core reset is held while the line is high. A short pulse is filtered out for qualification purposes. After a qualified reset falls, a fixed-length initialization phase runs, and then the core is released with its fetch address preset to the restart vector 0xFFFF0.

A pulse that stays high for too few clocks still aborts the running operation. In that case the core is released as soon as the line falls, with no initialization phase and no address load. If the line rises again during initialization, the sequencer goes back to counting from scratch. A separate synchronous block reset puts the sequencer into the initialization phase, so the core also receives a full start-up after power-on.

Top module: `rstq_seq`

## Requirements
- R1: While `rst_i` is high and on the edge that samples it, the sequencer enters initialization: `core_rst_o`=1, `busy_o`=1, `abort_o`=0, `start_load_o`=0. After `rst_i` falls with `cpu_rst_i` low, the core is released on the INIT_CYCLES-th following edge, with a load strobe.
- R2: On the first edge that samples `cpu_rst_i` high while the core is running or initializing, `abort_o` goes high for exactly one cycle. Further high samples of the same pulse give no further strobes.
- R3: A pulse counts as qualified only if `cpu_rst_i` is sampled high on more than MIN_HOLD (default 4) consecutive edges. A pulse of MIN_HOLD samples or fewer causes `core_rst_o` to fall on the first edge that samples the line low. That release carries no `start_load_o` pulse and no initialization phase.
- R4: After a qualified pulse, `core_rst_o` stays high for INIT_CYCLES (default 10) further cycles after the first edge that samples the line low. It falls on the INIT_CYCLES+1-th edge counted from that one.
- R5: When the initialization phase ends, `start_load_o` is high for exactly one cycle. That is the same cycle in which `core_rst_o` first reads low, and `start_addr_o` reads 0xFFFF0 (parameter RESTART_ADDR).
- R6: A high sample of `cpu_rst_i` during initialization aborts it, raises `abort_o` and restarts qualification counting at one. A following short total pulse then releases the core without initialization.
- R7: `busy_o` is high in exactly the cycles in which `core_rst_o` is high: while reset is held and throughout initialization.
- R8: `core_rst_o` is high in every cycle following an edge that sampled `cpu_rst_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high block reset (power-on) |
| cpu_rst_i | input | 1 | Synchronized external processor reset request, active high |
| core_rst_o | output | 1 | Reset held on the processor core |
| abort_o | output | 1 | One-cycle strobe that aborts the current operation |
| busy_o | output | 1 | Reset held or initialization in progress |
| start_addr_o | output | ADDR_W (20) | Restart fetch address |
| start_load_o | output | 1 | One-cycle strobe loading the restart address into the core |

## Verification
The bench builds the sequencer with its default parameters: a hold minimum of 4 samples, a 10-cycle initialization phase and a 20-bit restart vector. With these values, pulses of exactly 4 and 5 samples fall on both sides of the qualification limit. Re-raising the line at the first, middle and last initialization cycle exercises the restart path within a few hundred clocks. A behavioural model tracks the expected value of every output on every clock through these pulse patterns and back-to-back bursts.

// File: rtl/rstq_pkg.sv
package rstq_pkg;
  typedef enum logic [1:0] {
    PH_RUN  = 2'd0,
    PH_HOLD = 2'd1,
    PH_INIT = 2'd2
  } phase_e;
endpackage

// File: rtl/rstq_hold_cnt.sv
module rstq_hold_cnt #(
  parameter int MIN_HOLD = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic start_i,
  input  logic inc_i,
  output logic qualified_o
);
  localparam int W = $clog2(MIN_HOLD + 2);
  localparam logic [W-1:0] CAP = W'(MIN_HOLD + 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= W'(1);
    end else if (inc_i && cnt_q != CAP) begin
      cnt_q <= cnt_q + W'(1);
    end
  end

  assign qualified_o = (cnt_q == CAP);

  // R6
  restart_at_one_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    start_i |=> (cnt_q == W'(1)));

  // R3
  never_past_cap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    inc_i |=> (cnt_q <= CAP));
endmodule

// File: rtl/rstq_init_tmr.sv
module rstq_init_tmr #(
  parameter int INIT_CYCLES = 10
) (
  input  logic clk_i,
  input  logic clr_i,
  input  logic adv_i,
  output logic done_o
);
  localparam int W = $clog2(INIT_CYCLES + 1);
  localparam logic [W-1:0] LAST = W'(INIT_CYCLES - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (clr_i) begin
      cnt_q <= '0;
    end else if (adv_i && cnt_q != LAST) begin
      cnt_q <= cnt_q + W'(1);
    end
  end

  assign done_o = (cnt_q == LAST);

  // R4
  tmr_bounded_chk: assert property (@(posedge clk_i) disable iff (clr_i)
    adv_i |=> (cnt_q <= LAST));
endmodule

// File: rtl/rstq_seq.sv
module rstq_seq #(
  parameter int              MIN_HOLD     = 4,
  parameter int              INIT_CYCLES  = 10,
  parameter int              ADDR_W       = 20,
  parameter logic [ADDR_W-1:0] RESTART_ADDR = ADDR_W'(20'hFFFF0)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              cpu_rst_i,
  output logic              core_rst_o,
  output logic              abort_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] start_addr_o,
  output logic              start_load_o
);
  import rstq_pkg::*;

  phase_e phase_q;
  logic   qualified;
  logic   init_done;
  logic   hold_start;
  logic   hold_inc;
  logic   tmr_clr;
  logic   tmr_adv;

  assign hold_start = cpu_rst_i && (phase_q != PH_HOLD);
  assign hold_inc   = cpu_rst_i && (phase_q == PH_HOLD);
  assign tmr_clr    = rst_i || (phase_q != PH_INIT);
  assign tmr_adv    = (phase_q == PH_INIT) && !cpu_rst_i;

  rstq_hold_cnt #(.MIN_HOLD(MIN_HOLD)) u_hold (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .start_i    (hold_start),
    .inc_i      (hold_inc),
    .qualified_o(qualified)
  );

  rstq_init_tmr #(.INIT_CYCLES(INIT_CYCLES)) u_tmr (
    .clk_i (clk_i),
    .clr_i (tmr_clr),
    .adv_i (tmr_adv),
    .done_o(init_done)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      phase_q      <= PH_INIT;
      core_rst_o   <= 1'b1;
      busy_o       <= 1'b1;
      abort_o      <= 1'b0;
      start_load_o <= 1'b0;
      start_addr_o <= RESTART_ADDR;
    end else begin
      abort_o      <= 1'b0;
      start_load_o <= 1'b0;
      unique case (phase_q)
        PH_RUN: begin
          if (cpu_rst_i) begin
            phase_q    <= PH_HOLD;
            abort_o    <= 1'b1;
            core_rst_o <= 1'b1;
            busy_o     <= 1'b1;
          end
        end
        PH_HOLD: begin
          if (!cpu_rst_i) begin
            if (qualified) begin
              phase_q <= PH_INIT;
            end else begin
              phase_q    <= PH_RUN;
              core_rst_o <= 1'b0;
              busy_o     <= 1'b0;
            end
          end
        end
        PH_INIT: begin
          if (cpu_rst_i) begin
            phase_q <= PH_HOLD;
            abort_o <= 1'b1;
          end else if (init_done) begin
            phase_q      <= PH_RUN;
            core_rst_o   <= 1'b0;
            busy_o       <= 1'b0;
            start_load_o <= 1'b1;
            start_addr_o <= RESTART_ADDR;
          end
        end
        default: phase_q <= PH_RUN;
      endcase
    end
  end

  // R2
  abort_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    abort_o |=> !abort_o);

  // R2
  abort_needs_pin_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    abort_o |-> $past(cpu_rst_i));

  // R8
  pin_holds_core_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    cpu_rst_i |=> core_rst_o);

  // R5
  load_on_release_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(start_load_o) |-> (!core_rst_o && $past(core_rst_o)
                              && start_addr_o == RESTART_ADDR));

  // R5
  load_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    start_load_o |=> !start_load_o);

  // R7
  busy_tracks_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    busy_o == core_rst_o);
endmodule

// File: tb/rstq_seq_bench.sv
module rstq_seq_bench;
  localparam int MIN_HOLD = 4;
  localparam int INIT_CYCLES = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pin = 1'b0;
  logic        core_rst, abort_s, busy, load;
  logic [19:0] addr;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit armed  = 1'b0;
  bit done   = 1'b0;

  // behavioural reference state
  int mode  = 2;   // 0 running, 1 held, 2 initializing
  int held  = 0;
  int initc = 0;
  bit e_abort = 0, e_load = 0, e_rst = 1;
  int loads_seen = 0;

  always #5 clk = ~clk;

  rstq_seq u_rstq_seq (
    .clk_i       (clk),
    .rst_i       (rst),
    .cpu_rst_i   (pin),
    .core_rst_o  (core_rst),
    .abort_o     (abort_s),
    .busy_o      (busy),
    .start_addr_o(addr),
    .start_load_o(load)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cycles, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    e_abort = 0;
    e_load  = 0;
    if (rst) begin
      mode = 2; initc = 0; held = 0;
    end else begin
      case (mode)
        0: if (pin) begin mode = 1; held = 1; e_abort = 1; end
        1: if (pin) held++;
           else if (held > MIN_HOLD) begin mode = 2; initc = 0; end
           else mode = 0;
        default: if (pin) begin mode = 1; held = 1; e_abort = 1; end
                 else if (initc == INIT_CYCLES - 1) begin mode = 0; e_load = 1; end
                 else initc++;
      endcase
    end
    e_rst = (mode != 0);
    armed = 1'b1;
  end

  always @(negedge clk) begin
    if (armed && !done) begin
      check(core_rst === e_rst, "R4/R3/R8 core_rst", core_rst, e_rst);
      check(abort_s === e_abort, "R2/R6 abort", abort_s, e_abort);
      check(busy === e_rst, "R7 busy", busy, e_rst);
      check(load === e_load, "R5/R3 start_load", load, e_load);
      check(addr === 20'hFFFF0, "R5 start_addr", addr, 20'hFFFF0);
      if (load === 1'b1) loads_seen++;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input int n);
    @(negedge clk) pin = 1'b1;
    for (int i = 1; i < n; i++) @(negedge clk);
    @(negedge clk) pin = 1'b0;
  endtask

  initial begin
    idle(3);
    // R1: reset state held while rst high
    check(core_rst === 1'b1 && busy === 1'b1 && abort_s === 1'b0 && load === 1'b0,
          "R1 reset state", {core_rst, busy, abort_s, load}, 4'b1100);
    rst = 1'b0;
    idle(INIT_CYCLES + 4);
    check(loads_seen == 1, "R1 power-on release load count", loads_seen, 1);

    // R3: short pulses, no load strobe
    pulse(2);  idle(4);
    pulse(MIN_HOLD); idle(4);
    check(loads_seen == 1, "R3 short pulse gives no load", loads_seen, 1);
    check(core_rst === 1'b0, "R3 short pulse releases core", core_rst, 0);

    // R4/R5: boundary long pulse and longer
    pulse(MIN_HOLD + 1); idle(INIT_CYCLES + 4);
    check(loads_seen == 2, "R4 qualified pulse loads once", loads_seen, 2);
    pulse(8); idle(INIT_CYCLES + 4);

    // R6: re-rise at start, middle, last init cycle
    pulse(6); pulse(3); idle(INIT_CYCLES + 4);
    pulse(6); idle(5); pulse(6); idle(INIT_CYCLES + 4);
    pulse(6); idle(INIT_CYCLES - 1); pulse(2); idle(6);
    check(core_rst === 1'b0, "R6 short re-rise releases core", core_rst, 0);

    // back-to-back bursts
    pulse(1); pulse(1); pulse(5); pulse(1); idle(INIT_CYCLES + 4);
    // R1: block reset in the middle of a held pulse
    @(negedge clk) pin = 1'b1;
    idle(2);
    rst = 1'b1; pin = 1'b0;
    idle(2);
    rst = 1'b0;
    idle(INIT_CYCLES + 4);
    check(core_rst === 1'b0 && busy === 1'b0, "R1 release after block reset",
          {core_rst, busy}, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired: actual=%0d expected=%0d", cycles, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule